// File: doc/BRIEF.md
# I2C Bus Lock-Up Recovery Sequencer

This block sits next to an I2C master controller and frees a bus that a slave holds stuck. The typical fault is a transfer that loses its ninth (acknowledge) SCL pulse. The slave then keeps SDA low while it waits for that clock. The master can no longer read the slave or produce a STOP, so its busy waits only time out. A watchdog counts system clocks while a transfer is outstanding and either bus line reads low. When the count reaches a programmable limit, or when software raises an explicit request, the sequencer takes over the open-drain lines.

Recovery runs in a fixed order. First the controller is switched off and then on again. Then SCL is released and read back high. SDA is pulled low to form a START, SCL is pulled low, SCL is released again, and SDA is released to form a STOP. Together these steps supply the missing clock pulse. Every phase is timed by a programmable half-period count, so the bus timing does not depend on the system clock frequency. A phase that needs SCL high also waits for SCL to read back high, which honours clock stretching.

After each STOP the sequencer samples SDA. If SDA is high, the bus is free. The block then emits a one-cycle pulse and raises a retry request, which tells the master to replay the interrupted transfer from its start. If SDA is still low, another clock pulse is issued. When the pulse limit is used up, a sticky error is raised. Both bus inputs pass through a two-flop synchroniser before any decision uses them.

Top module: `i2c_lockup_recovery`

## Requirements
- R1: After reset: ctrl_en_o=1, scl_oe_o=0, sda_oe_o=0, owns_bus_o=0, recovered_o=0, retry_o=0, error_o=0.
- R2: While idle with busy_i=1 and the synchronised SCL or SDA low, a counter runs. ctrl_en_o falls tmo_lim_i+2 clock edges after the first edge that samples the low line. A tmo_lim_i of 0 disables the watchdog.
- R3: With busy_i=0, a low bus line never starts recovery.
- R4: rec_req_i=1 while idle starts recovery: ctrl_en_o goes low on the next clock edge.
- R5: The order of events is ctrl_en_o low, then ctrl_en_o high, then for each pulse: sda_oe_o rises, scl_oe_o rises, scl_oe_o falls, sda_oe_o falls. The oe outputs are 1 to pull the line low.
- R6: sda_oe_o changes (START and STOP) only while SCL reads high. scl_oe_o is 1 only while sda_oe_o is 1.
- R7: ctrl_en_o stays low for exactly half_lim_i+1 cycles. Each bus phase lasts at least half_lim_i+1 cycles. The release of SCL before a START or STOP also waits until SCL reads back high, so a slave that stretches the clock lengthens the phase.
- R8: If SDA reads high at the end of a STOP, recovered_o pulses for exactly one cycle, retry_o is set, and the block returns to idle.
- R9: If SDA still reads low, the pulse is repeated. After MAX_PULSES (default 9) failed pulses, error_o is set and the bus is released without a retry.
- R10: retry_o stays 1 until retry_ack_i is sampled high, and it clears on that edge.
- R11: error_o stays 1 until reset, including through later successful recoveries.
- R12: Outside recovery (owns_bus_o=0) the block drives neither line and ctrl_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Master has a transfer outstanding |
| rec_req_i | input | 1 | Explicit recovery request |
| retry_ack_i | input | 1 | Master accepts the retry request |
| tmo_lim_i | input | TMO_W | Bus-stuck timeout in system clocks, 0 disables |
| half_lim_i | input | HALF_W | Half SCL period minus one, in system clocks |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| ctrl_en_o | output | 1 | Enable for the master controller |
| owns_bus_o | output | 1 | Sequencer controls the lines |
| recovered_o | output | 1 | One-cycle pulse when the bus is freed |
| retry_o | output | 1 | Replay the interrupted transfer |
| error_o | output | 1 | Sticky: bus could not be freed |

## Verification
The timeout start is due tmo_lim_i+3 bench cycles after the negedge that drives the line low: two synchroniser flops, the count itself and the state register. An explicit request is due one edge after it is driven. The driver task pushes each expected event into a queue together with an exact cycle stamp where the stamp is fixed (the recovery start). Where the timing depends on SCL read-back or on stretching, it pushes a minimum gap to the previous event instead. The monitor samples 5 ns after each rising edge, detects each output transition, and checks it against the head of the queue for code, stamp or gap, and SCL level. The retry and error flags are checked at negedges once the queue is empty.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIS,
    ST_EN,
    ST_REL,
    ST_START,
    ST_SCLLO,
    ST_STOPSU,
    ST_STOP,
    ST_CHECK
  } rec_state_e;
endpackage

// File: rtl/i2c_rec_sync.sv
module i2c_rec_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic ff1_q, ff2_q;
    // bus idles high, so reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= 1'b1;
        ff2_q <= 1'b1;
      end else begin
        ff1_q <= d_i[b];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[b] = ff2_q;
  end
endmodule

// File: rtl/i2c_rec_wdog.sv
module i2c_rec_wdog #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          busy_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;
  logic          cond;

  assign cond  = arm_i && busy_i && (!scl_s_i || !sda_s_i);
  assign hit_o = cond && (lim_i != '0) && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!cond)          cnt_q <= '0;
    else if (cnt_q != lim_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_rec_timer.sv
module i2c_rec_timer #(
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [PW-1:0] lim_i,
  output logic          done_o
);
  logic [PW-1:0] cnt_q;

  assign done_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_rec_fsm.sv
module i2c_rec_fsm
  import i2c_rec_pkg::*;
#(
  parameter int MAX_PULSES = 9,
  localparam int PCW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic retry_ack_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic tdone_i,
  output logic tclr_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic ctrl_en_o,
  output logic owns_bus_o,
  output logic recovered_o,
  output logic retry_o,
  output logic error_o
);
  rec_state_e     state_q, state_d;
  logic [PCW-1:0] pulse_q;
  logic           retry_q, error_q;
  logic           last_pulse, fail;

  assign last_pulse = (pulse_q == PCW'(MAX_PULSES - 1));
  assign fail       = (state_q == ST_CHECK) && !sda_s_i && last_pulse;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_DIS;
      ST_DIS:    if (tdone_i) state_d = ST_EN;
      ST_EN:     if (tdone_i) state_d = ST_REL;
      ST_REL:    if (tdone_i && scl_s_i) state_d = ST_START;
      ST_START:  if (tdone_i) state_d = ST_SCLLO;
      ST_SCLLO:  if (tdone_i) state_d = ST_STOPSU;
      ST_STOPSU: if (tdone_i && scl_s_i) state_d = ST_STOP;
      ST_STOP:   if (tdone_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (sda_s_i || last_pulse) state_d = ST_IDLE;
        else                       state_d = ST_REL;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tclr_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      retry_q <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DIS) pulse_q <= '0;
      else if (state_q == ST_CHECK && !sda_s_i && !last_pulse) pulse_q <= pulse_q + 1'b1;
      if (recovered_o)      retry_q <= 1'b1;
      else if (retry_ack_i) retry_q <= 1'b0;
      if (fail) error_q <= 1'b1;
    end
  end

  assign ctrl_en_o   = (state_q != ST_DIS);
  assign owns_bus_o  = (state_q != ST_IDLE);
  assign scl_oe_o    = (state_q == ST_SCLLO);
  assign sda_oe_o    = (state_q == ST_START) || (state_q == ST_SCLLO) || (state_q == ST_STOPSU);
  assign recovered_o = (state_q == ST_CHECK) && sda_s_i;
  assign retry_o     = retry_q;
  assign error_o     = error_q;
endmodule

// File: rtl/i2c_lockup_recovery.sv
module i2c_lockup_recovery #(
  parameter int TMO_W      = 16,
  parameter int HALF_W     = 12,
  parameter int MAX_PULSES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              rec_req_i,
  input  logic              retry_ack_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic [HALF_W-1:0] half_lim_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              ctrl_en_o,
  output logic              owns_bus_o,
  output logic              recovered_o,
  output logic              retry_o,
  output logic              error_o
);
  logic [1:0] pads_s;
  logic       scl_s, sda_s;
  logic       tmo_hit, tclr, tdone;

  i2c_rec_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (pads_s)
  );
  assign scl_s = pads_s[1];
  assign sda_s = pads_s[0];

  i2c_rec_wdog #(.TW(TMO_W)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (!owns_bus_o),
    .busy_i (busy_i),
    .scl_s_i(scl_s),
    .sda_s_i(sda_s),
    .lim_i  (tmo_lim_i),
    .hit_o  (tmo_hit)
  );

  i2c_rec_timer #(.PW(HALF_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tclr),
    .lim_i (half_lim_i),
    .done_o(tdone)
  );

  i2c_rec_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rec_req_i || tmo_hit),
    .retry_ack_i(retry_ack_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .tdone_i    (tdone),
    .tclr_o     (tclr),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .ctrl_en_o  (ctrl_en_o),
    .owns_bus_o (owns_bus_o),
    .recovered_o(recovered_o),
    .retry_o    (retry_o),
    .error_o    (error_o)
  );
endmodule

// File: rtl/i2c_rec_chk.sv
module i2c_rec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic retry_ack_i,
  input logic scl_s_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic ctrl_en_o,
  input logic owns_bus_o,
  input logic recovered_o,
  input logic retry_o,
  input logic error_o
);
  p_start_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_s_i));
  p_stop_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> $past(scl_s_i));
  p_scl_under_sda_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> sda_oe_o);
  p_ctrl_off_owned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_o |-> owns_bus_o);
  p_recov_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovered_o |=> !recovered_o);
  p_recov_sets_retry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovered_o |=> retry_o);
  p_retry_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o && !retry_ack_i |=> retry_o);
  p_error_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !owns_bus_o |-> (!scl_oe_o && !sda_oe_o && ctrl_en_o));
endmodule

bind i2c_lockup_recovery i2c_rec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .retry_ack_i(retry_ack_i),
  .scl_s_i    (scl_s),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .ctrl_en_o  (ctrl_en_o),
  .owns_bus_o (owns_bus_o),
  .recovered_o(recovered_o),
  .retry_o    (retry_o),
  .error_o    (error_o)
);

// File: tb/test_i2c_lockup_recovery.sv
`timescale 1ns/1ps
module test_i2c_lockup_recovery;
  localparam int H       = 10;
  localparam int LIM     = 50;
  localparam int STRETCH = 40;
  localparam int MAXP    = 9;

  localparam int E_EN_FALL = 0, E_EN_RISE = 1, E_SDA_DRV = 2, E_SCL_DRV = 3,
                 E_SCL_REL = 4, E_SDA_REL = 5, E_RECOV = 6, E_ERROR = 7;

  typedef struct {
    int code;
    int stamp;
    int min_gap;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic busy = 1'b0, rec_req = 1'b0, ack = 1'b0;
  logic [15:0] tmo_lim = 16'(LIM);
  logic [11:0] half_lim = 12'(H);
  logic scl_oe, sda_oe, ctrl_en, owns, recovered, retry, err;
  wire  scl_pad, sda_pad;

  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  // slave model
  bit hold_on = 1'b0;
  int rel_at = 0;
  int rise_cnt = 0;
  bit stretch_en = 1'b0;
  bit slv_scl_low = 1'b0;
  int st_cnt = 0;
  bit prev_oe = 1'b0;

  assign scl_pad = !(scl_oe || slv_scl_low);
  assign sda_pad = !(sda_oe || (hold_on && (rise_cnt < rel_at)));

  i2c_lockup_recovery i_i2c_lockup_recovery (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .rec_req_i  (rec_req),
    .retry_ack_i(ack),
    .tmo_lim_i  (tmo_lim),
    .half_lim_i (half_lim),
    .scl_i      (scl_pad),
    .sda_i      (sda_pad),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .ctrl_en_o  (ctrl_en),
    .owns_bus_o (owns),
    .recovered_o(recovered),
    .retry_o    (retry),
    .error_o    (err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scl_oe && !prev_oe) rise_cnt = rise_cnt + 1;
    if (!scl_oe && prev_oe && stretch_en) begin
      slv_scl_low = 1'b1;
      st_cnt = STRETCH;
    end else if (st_cnt > 0) begin
      st_cnt = st_cnt - 1;
      if (st_cnt == 0) slv_scl_low = 1'b0;
    end
    prev_oe = scl_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int code, input int stamp, input int gap);
    exp_t e;
    e.code = code; e.stamp = stamp; e.min_gap = gap;
    q.push_back(e);
  endtask

  task automatic push_pulse(input int stop_gap);
    push(E_SDA_DRV, -1, 2*H+2);
    push(E_SCL_DRV, -1, H+1);
    push(E_SCL_REL, -1, H+1);
    push(E_SDA_REL, -1, stop_gap);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R5 all expected events seen", q.size(), 0);
  endtask

  // monitor / scoreboard
  int  last_stamp = 0;
  bit  p_en = 1'b1, p_sda = 1'b0, p_scl = 1'b0, p_rec = 1'b0, p_err = 1'b0;

  task automatic got(input int code);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R12 unexpected event", code, -1);
    end else begin
      e = q.pop_front();
      chk(e.code == code, "R5 event order", code, e.code);
      if (e.stamp >= 0) chk(cyc == e.stamp, "R2/R4 start cycle", cyc, e.stamp);
      chk(cyc - last_stamp >= e.min_gap, "R7 phase length", cyc - last_stamp, e.min_gap);
      if (code == E_SDA_DRV || code == E_SDA_REL)
        chk(scl_pad == 1'b1, "R6 SCL high at START/STOP", scl_pad, 1);
    end
    last_stamp = cyc;
  endtask

  always begin
    @(posedge clk);
    #5;
    if (rst_ni) begin
      if (p_en && !ctrl_en)    got(E_EN_FALL);
      if (!p_en && ctrl_en)    got(E_EN_RISE);
      if (!p_sda && sda_oe)    got(E_SDA_DRV);
      if (!p_scl && scl_oe)    got(E_SCL_DRV);
      if (p_scl && !scl_oe)    got(E_SCL_REL);
      if (p_sda && !sda_oe)    got(E_SDA_REL);
      if (!p_rec && recovered) got(E_RECOV);
      if (p_rec && recovered)  chk(1'b0, "R8 recovered one cycle", 1, 0);
      if (!p_err && err)       got(E_ERROR);
    end
    p_en = ctrl_en; p_sda = sda_oe; p_scl = scl_oe; p_rec = recovered; p_err = err;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_en == 1'b1, "R1 ctrl_en", ctrl_en, 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 no drive", {scl_oe, sda_oe}, 0);
    chk(owns == 1'b0, "R1 owns", owns, 0);
    chk(retry == 1'b0 && err == 1'b0 && recovered == 1'b0, "R1 flags",
        {retry, err, recovered}, 0);

    // R3: stuck SDA with no transfer outstanding is ignored
    hold_on = 1'b1; rel_at = rise_cnt + 1000;
    repeat (LIM + 30) @(negedge clk);
    chk(owns == 1'b0 && ctrl_en == 1'b1, "R3 no recovery when not busy", owns, 0);
    hold_on = 1'b0;
    repeat (5) @(negedge clk);

    // R2: timeout with a slave that frees SDA after one clock
    busy = 1'b1;
    repeat (3) @(negedge clk);
    n = cyc;
    push(E_EN_FALL, n + LIM + 3, 0);
    push(E_EN_RISE, -1, H+1);
    push_pulse(H+1);
    push(E_RECOV, -1, H+1);
    hold_on = 1'b1; rel_at = rise_cnt + 1;
    drain();
    busy = 1'b0; hold_on = 1'b0;
    @(negedge clk);
    // R10: retry stays until acknowledged
    chk(retry == 1'b1, "R8 retry set after recovery", retry, 1);
    repeat (6) @(negedge clk);
    chk(retry == 1'b1, "R10 retry held", retry, 1);
    chk(owns == 1'b0 && ctrl_en == 1'b1, "R12 idle after recovery", owns, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(retry == 1'b0, "R10 retry cleared by ack", retry, 0);

    // R4 + R9 + R7: explicit request, three pulses, slave stretches SCL
    stretch_en = 1'b1;
    hold_on = 1'b1; rel_at = rise_cnt + 3;
    @(negedge clk);
    n = cyc;
    rec_req = 1'b1;
    push(E_EN_FALL, n + 1, 0);
    push(E_EN_RISE, -1, H+1);
    for (int i = 0; i < 3; i++) push_pulse(STRETCH);
    push(E_RECOV, -1, H+1);
    @(negedge clk);
    rec_req = 1'b0;
    drain();
    repeat (2) @(negedge clk);
    chk(retry == 1'b1 && err == 1'b0, "R9 recovered after repeated pulses", {retry, err}, 2);
    stretch_en = 1'b0; hold_on = 1'b0;
    ack = 1'b1; @(negedge clk); ack = 1'b0;

    // R9: slave never lets go, error after MAX_PULSES
    hold_on = 1'b1; rel_at = rise_cnt + 1000;
    @(negedge clk);
    n = cyc;
    rec_req = 1'b1;
    push(E_EN_FALL, n + 1, 0);
    push(E_EN_RISE, -1, H+1);
    for (int i = 0; i < MAXP; i++) push_pulse(H+1);
    push(E_ERROR, -1, H+2);
    @(negedge clk);
    rec_req = 1'b0;
    drain();
    @(negedge clk);
    chk(err == 1'b1, "R9 error after pulse limit", err, 1);
    chk(retry == 1'b0, "R9 no retry on failure", retry, 0);
    chk(owns == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R12 bus released after error",
        {owns, scl_oe, sda_oe}, 0);
    hold_on = 1'b0;
    repeat (4) @(negedge clk);

    // R11: error survives a later successful recovery
    @(negedge clk);
    n = cyc;
    rec_req = 1'b1;
    push(E_EN_FALL, n + 1, 0);
    push(E_EN_RISE, -1, H+1);
    push_pulse(H+1);
    push(E_RECOV, -1, H+1);
    @(negedge clk);
    rec_req = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R11 error sticky", err, 1);
    chk(retry == 1'b1, "R8 retry after clean bus", retry, 1);

    // R2: a zero limit disables the watchdog
    tmo_lim = '0;
    busy = 1'b1; hold_on = 1'b1; rel_at = rise_cnt + 1000;
    repeat (200) @(negedge clk);
    chk(owns == 1'b0, "R2 zero limit disables timeout", owns, 0);
    busy = 1'b0; hold_on = 1'b0;
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R12 no stray events", q.size(), 0);
    summary();
  end
endmodule